// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the bus-side command state machine of a byte-wide NOR-style flash model. It samples host write cycles, each presented as a one-cycle strobe marking the rising edge of write-enable, together with the write address and data byte. It recognises the unlock prefix, the set-up byte and the command bytes. From these it selects what the read path returns: array data, identification bytes or the status byte of the erase engine.

Three command sequences are supported: reset, identification read and chip erase. A completed chip-erase sequence fires a one-cycle start pulse to a separate erase engine. While that engine runs, the decoder shows its status byte and accepts no further commands. The one exception is the reset byte, which is accepted only after the engine has flagged a failure; it then aborts the operation.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the read mode is array read (`rd_mode` = 0), `rd_data` follows `array_rdata`, and `erase_go` and `erase_abort` are low.
- R2: A write of F0h to any address, while no erase is running, sets array-read mode (`rd_mode` = 0). The mode stays there while no further writes occur.
- R3: The writes AAh@555h, 55h@2AAh, 90h@555h enter identification mode (`rd_mode` = 1). In that mode, a read with `rd_addr[1:0]` = 00 returns C2h.
- R4: In identification mode, `rd_addr[1:0]` = 01 returns the device byte. This is B0h when `BOOT_TOP` = 1 and 34h when `BOOT_TOP` = 0.
- R5: In identification mode, `rd_addr[1:0]` = 10 returns 01h when `sect_prot` is high and 00h when it is low. `rd_addr[1:0]` = 11 returns 00h.
- R6: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `erase_go` for exactly one cycle, the cycle after the sixth strobe is sampled. At the same point the mode becomes status (`rd_mode` = 2), and `rd_data` then follows `eng_status`.
- R7: A write that does not match the next expected step of a sequence returns the decoder to array read without pulsing `erase_go`.
- R8: While an erase runs, every write is ignored: the mode stays status and no pulse is produced. This includes F0h written while `eng_fail` is low and full identification sequences.
- R9: While an erase runs with `eng_fail` high, a write of F0h pulses `erase_abort` for one cycle and returns to array read.
- R10: An `eng_done` pulse while an erase runs returns the decoder to array read.
- R11: Only the low `CMD_AW` bits of `wr_addr` take part in command address matching. Upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle strobe: write-enable rising edge |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read address |
| array_rdata | input | 8 | Byte from the storage array |
| sect_prot | input | 1 | Protection flag of the addressed sector |
| eng_status | input | 8 | Status byte from the erase engine |
| eng_done | input | 1 | Erase engine finished successfully (pulse) |
| eng_fail | input | 1 | Erase engine failure flag (level) |
| erase_go | output | 1 | Chip-erase start pulse |
| erase_abort | output | 1 | Abort pulse to the erase engine |
| rd_mode | output | 2 | 0 array, 1 identification, 2 status |
| rd_data | output | 8 | Read data |

## Verification
A wrong sequence state shows first on `rd_mode` and `rd_data`, and it does so in the cycle after the offending strobe. For example, a lost unlock step leaves `rd_mode` at 0 where the bench expects identification bytes. A wrong transition out of the busy state shows as status data replaced by array data one cycle after the write. A misplaced or doubled start pulse is visible on `erase_go` in exactly the cycle after the sixth strobe, and the bench samples that cycle and the one after it.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
   typedef enum logic [3:0] {
      S_ARRAY, S_UNL1, S_UNL2, S_IDENT,
      S_ESET, S_EUNL1, S_EUNL2, S_ERASE
   } seq_state_e;

   localparam logic [1:0] MODE_ARRAY  = 2'd0;
   localparam logic [1:0] MODE_IDENT  = 2'd1;
   localparam logic [1:0] MODE_STATUS = 2'd2;

   localparam logic [7:0] BYTE_UNL1  = 8'hAA;
   localparam logic [7:0] BYTE_UNL2  = 8'h55;
   localparam logic [7:0] BYTE_IDENT = 8'h90;
   localparam logic [7:0] BYTE_SETUP = 8'h80;
   localparam logic [7:0] BYTE_CHIP  = 8'h10;
   localparam logic [7:0] BYTE_RESET = 8'hF0;

   typedef struct packed {
      logic unl1;
      logic unl2;
      logic ident;
      logic setup;
      logic chip;
      logic rst;
   } cmd_hit_t;
endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int CMD_AW = 11
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   output cmd_hit_t          hit
);
   localparam logic [CMD_AW-1:0] ADR_A = CMD_AW'(12'h555);
   localparam logic [CMD_AW-1:0] ADR_B = CMD_AW'(12'h2AA);

   generate
      if (CMD_AW < 11 || CMD_AW > ADDR_W) begin : g_bad_aw
         $error("nor_cmd_match: CMD_AW must be within 11..ADDR_W");
      end
   endgenerate

   logic [CMD_AW-1:0] low;
   logic              at_a, at_b;

   always_comb begin
      low       = addr[CMD_AW-1:0];
      at_a      = (low == ADR_A);
      at_b      = (low == ADR_B);
      hit.unl1  = at_a && (data == BYTE_UNL1);
      hit.unl2  = at_b && (data == BYTE_UNL2);
      hit.ident = at_a && (data == BYTE_IDENT);
      hit.setup = at_a && (data == BYTE_SETUP);
      hit.chip  = at_a && (data == BYTE_CHIP);
      hit.rst   = (data == BYTE_RESET);
   end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
   import nor_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  cmd_hit_t   hit,
   input  logic       eng_done,
   input  logic       eng_fail,
   output seq_state_e st_q,
   output logic       erase_go,
   output logic       erase_abort
);
   seq_state_e st_d;
   logic       go_d, abort_d, abort_now;

   assign abort_now = wr_stb && hit.rst && eng_fail;

   always_comb begin
      st_d    = st_q;
      go_d    = 1'b0;
      abort_d = 1'b0;
      if (st_q == S_ERASE) begin
         if (eng_done) begin
            st_d = S_ARRAY;
         end else if (abort_now) begin
            st_d    = S_ARRAY;
            abort_d = 1'b1;
         end
      end else if (wr_stb) begin
         if (hit.rst) begin
            st_d = S_ARRAY;
         end else begin
            st_d = S_ARRAY;
            unique case (st_q)
               S_ARRAY, S_IDENT: if (hit.unl1) st_d = S_UNL1;
               S_UNL1:           if (hit.unl2) st_d = S_UNL2;
               S_UNL2: begin
                  if (hit.ident)      st_d = S_IDENT;
                  else if (hit.setup) st_d = S_ESET;
               end
               S_ESET:           if (hit.unl1) st_d = S_EUNL1;
               S_EUNL1:          if (hit.unl2) st_d = S_EUNL2;
               S_EUNL2: if (hit.chip) begin
                  st_d = S_ERASE;
                  go_d = 1'b1;
               end
               default:          st_d = S_ARRAY;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= S_ARRAY;
         erase_go    <= 1'b0;
         erase_abort <= 1'b0;
      end else begin
         st_q        <= st_d;
         erase_go    <= go_d;
         erase_abort <= abort_d;
      end
   end

   // R6
   erase_go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |=> !erase_go);
   // R6
   erase_go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |-> st_q == S_ERASE);
   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_ERASE && !eng_done && !abort_now) |=> st_q == S_ERASE);
   // R9
   abort_needs_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_abort |-> ($past(eng_fail) && st_q == S_ARRAY));
   // R1
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erase_go, erase_abort}));
endmodule

// File: rtl/nor_id_codes.sv
module nor_id_codes #(
   parameter bit BOOT_TOP = 1'b1
) (
   input  logic [1:0] sel,
   input  logic       sect_prot,
   output logic [7:0] id_byte
);
   localparam logic [7:0] MFR_BYTE = 8'hC2;
   logic [7:0] dev_byte;

   generate
      if (BOOT_TOP) begin : g_top
         assign dev_byte = 8'hB0;
      end else begin : g_bottom
         assign dev_byte = 8'h34;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         2'b00:   id_byte = MFR_BYTE;
         2'b01:   id_byte = dev_byte;
         2'b10:   id_byte = {7'd0, sect_prot};
         default: id_byte = 8'h00;
      endcase
   end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int CMD_AW   = 11,
   parameter bit BOOT_TOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        array_rdata,
   input  logic              sect_prot,
   input  logic [7:0]        eng_status,
   input  logic              eng_done,
   input  logic              eng_fail,
   output logic              erase_go,
   output logic              erase_abort,
   output logic [1:0]        rd_mode,
   output logic [7:0]        rd_data
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("nor_cmd_seq: ADDR_W must be at least 2");
      end
   endgenerate

   cmd_hit_t   hit;
   seq_state_e st_q;
   logic [7:0] id_byte;

   nor_cmd_match #(.ADDR_W(ADDR_W), .CMD_AW(CMD_AW)) u_match (
      .addr (wr_addr),
      .data (wr_data),
      .hit  (hit)
   );

   nor_cmd_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_stb),
      .hit         (hit),
      .eng_done    (eng_done),
      .eng_fail    (eng_fail),
      .st_q        (st_q),
      .erase_go    (erase_go),
      .erase_abort (erase_abort)
   );

   nor_id_codes #(.BOOT_TOP(BOOT_TOP)) u_id (
      .sel       (rd_addr[1:0]),
      .sect_prot (sect_prot),
      .id_byte   (id_byte)
   );

   always_comb begin
      unique case (st_q)
         S_IDENT: rd_mode = MODE_IDENT;
         S_ERASE: rd_mode = MODE_STATUS;
         default: rd_mode = MODE_ARRAY;
      endcase
   end

   always_comb begin
      unique case (rd_mode)
         MODE_IDENT:  rd_data = id_byte;
         MODE_STATUS: rd_data = eng_status;
         default:     rd_data = array_rdata;
      endcase
   end

   // R2
   mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && st_q != S_ERASE) |=> $stable(rd_mode));
   // R3
   ident_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != S_IDENT && !(st_q == S_UNL2 && wr_stb && hit.ident)) |=> st_q != S_IDENT);
endmodule

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    array_rdata = 8'h3C;
   logic          sect_prot = 1'b0;
   logic [7:0]    eng_status = 8'h5A;
   logic          eng_done = 1'b0;
   logic          eng_fail = 1'b0;
   logic          erase_go, erase_abort, b_go, b_abort;
   logic [1:0]    rd_mode, b_mode;
   logic [7:0]    rd_data, b_data;

   int n_chk = 0;
   int n_bad = 0;
   logic saw_go, saw_abort;

   always #4 clk = ~clk;

   nor_cmd_seq #(.ADDR_W(AW)) u_nor_cmd_seq (
      .clk, .rst_n, .wr_stb, .wr_addr, .wr_data, .rd_addr, .array_rdata,
      .sect_prot, .eng_status, .eng_done, .eng_fail,
      .erase_go, .erase_abort, .rd_mode, .rd_data
   );

   nor_cmd_seq #(.ADDR_W(AW), .BOOT_TOP(1'b0)) u_bot (
      .clk, .rst_n, .wr_stb, .wr_addr, .wr_data, .rd_addr, .array_rdata,
      .sect_prot, .eng_status, .eng_done, .eng_fail,
      .erase_go(b_go), .erase_abort(b_abort), .rd_mode(b_mode), .rd_data(b_data)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one write strobe; result state is visible at the returning negedge
   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
      saw_go = erase_go;
      saw_abort = erase_abort;
   endtask

   task automatic rd(input logic [1:0] a, input string tag, input int exp);
      rd_addr = {16'h1234, a};
      #1 chk(tag, rd_data, exp);
   endtask

   task automatic seq_ident();
      wr(18'h555, 8'hAA); wr(18'h2AA, 8'h55); wr(18'h555, 8'h90);
   endtask

   task automatic seq_erase();
      wr(18'h555, 8'hAA); wr(18'h2AA, 8'h55); wr(18'h555, 8'h80);
      wr(18'h555, 8'hAA); wr(18'h2AA, 8'h55); wr(18'h555, 8'h10);
   endtask

   task automatic t_reset();
      #1;
      chk("R1 mode", rd_mode, 0);
      chk("R1 data", rd_data, 8'h3C);
      chk("R1 go", erase_go, 0);
      chk("R1 abort", erase_abort, 0);
   endtask

   task automatic t_ident();
      seq_ident();
      chk("R3 mode", rd_mode, 1);
      rd(2'b00, "R3 mfr", 8'hC2);
      rd(2'b01, "R4 dev top", 8'hB0);
      #1 chk("R4 dev bottom", b_data, 8'h34);
      sect_prot = 1'b1;
      rd(2'b10, "R5 prot", 8'h01);
      sect_prot = 1'b0;
      rd(2'b10, "R5 unprot", 8'h00);
      rd(2'b11, "R5 spare", 8'h00);
   endtask

   task automatic t_reset_cmd();
      wr(18'h3FFFF, 8'hF0);
      chk("R2 mode", rd_mode, 0);
      rd(2'b00, "R2 array data", 8'h3C);
      repeat (3) @(negedge clk);
      chk("R2 mode held", rd_mode, 0);
   endtask

   task automatic t_broken();
      wr(18'h555, 8'hAA); wr(18'h2AA, 8'h55); wr(18'h555, 8'h80);
      wr(18'h555, 8'hAA); wr(18'h2AB, 8'h55);
      chk("R7 bad addr mode", rd_mode, 0);
      wr(18'h555, 8'h10);
      chk("R7 no go", saw_go, 0);
      chk("R7 mode after", rd_mode, 0);
      seq_ident();
      wr(18'h555, 8'h12);
      chk("R7 ident left", rd_mode, 0);
   endtask

   task automatic t_erase();
      seq_erase();
      chk("R6 go pulse", saw_go, 1);
      chk("R6 mode", rd_mode, 2);
      rd(2'b00, "R6 status", 8'h5A);
      @(negedge clk);
      chk("R6 go single", erase_go, 0);
   endtask

   task automatic t_busy();
      seq_ident();
      chk("R8 ident ignored", rd_mode, 2);
      wr(18'h555, 8'hF0);
      chk("R8 F0 no fail", rd_mode, 2);
      chk("R8 no abort", saw_abort, 0);
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
      chk("R10 done", rd_mode, 0);
   endtask

   task automatic t_abort();
      seq_erase();
      eng_fail = 1'b1;
      wr(18'h0, 8'hF0);
      chk("R9 abort pulse", saw_abort, 1);
      chk("R9 mode", rd_mode, 0);
      eng_fail = 1'b0;
      @(negedge clk);
      chk("R9 abort single", erase_abort, 0);
   endtask

   task automatic t_upper();
      wr(18'h3F555, 8'hAA); wr(18'h1C2AA, 8'h55); wr(18'h20555, 8'h90);
      chk("R11 upper bits ignored", rd_mode, 1);
      wr(18'h0, 8'hF0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ident();
      t_reset_cmd();
      t_broken();
      t_erase();
      t_busy();
      t_abort();
      t_upper();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule